// File: doc/BRIEF.md
# Compression Reference Classifier

This block sorts each second-level cache reference to a compressed set into one of five classes. It compares what the compressed cache did with what a plain cache of four uncompressed lines per set would have done. The lookup logic supplies the outcome of the tag search: whether a tag matched, whether that tag still holds data, whether the line is stored compressed, and the recency position of the match. It also supplies the compressed size, in segments, of the line at every recency position. The block returns a one-hot class word. A compression predictor reads that word to weigh the benefit of compression against its cost.

Hits are split by recency. In the first four positions a hit would also have hit without compression, so the only open question is whether a decompression delay was paid. In the deeper positions the hit exists only because compression made room for the line. A match on a tag that has lost its data is a miss. Whether compression could have saved it is settled by adding up the compressed sizes from the most recent position down to the match and comparing that total with the segment capacity of the set. The result is combinational and is valid in the same cycle as the lookup inputs.

Top module: `ccls_ref_classifier`

## Requirements
- R1: `ref_class` always has exactly one bit set. The bit positions are: 0 unpenalized hit, 1 penalized hit, 2 avoided miss, 3 avoidable miss, 4 unavoidable miss.
- R2: A hit (`lk_tag_hit`=1, `lk_data_ok`=1) with `lk_depth` 0 to 3 on an uncompressed line (`lk_compressed`=0) gives an unpenalized hit. `lk_depth` 0 is the most recent position.
- R3: A hit with `lk_depth` 0 to 3 on a compressed line (`lk_compressed`=1) gives a penalized hit.
- R4: A hit with `lk_depth` 4 to 7 gives an avoided miss, whatever the value of `lk_compressed`.
- R5: When `lk_tag_hit`=0 the class is unavoidable miss, whatever the other inputs hold.
- R6: A tag match without data (`lk_tag_hit`=1, `lk_data_ok`=0) gives an avoidable miss when the sum of the size fields for depths 0 up to and including `lk_depth` is 32 or less. The size for depth i is `seg_sizes[4*i+3:4*i]`.
- R7: The same tag-only match gives an unavoidable miss when that sum exceeds 32. For example, a sum of 35 gives an unavoidable miss.
- R8: Size fields at depths beyond `lk_depth` have no effect on the class.
- R9: The class follows the inputs combinationally, in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lk_tag_hit | input | 1 | A tag in the set matched the reference address |
| lk_data_ok | input | 1 | The matched tag still holds valid data |
| lk_compressed | input | 1 | The matched line is stored in compressed form |
| lk_depth | input | 3 | Recency position of the match, 0 being most recent |
| seg_sizes | input | 32 | Compressed size in segments for each recency position, 4 bits per position |
| ref_class | output | 5 | One-hot reference class |

## Verification
On every evaluation, the assertions check that the class is one-hot and that a missing tag always yields an unavoidable miss. They also check that any deep hit yields an avoided miss, and that the running size total stays within the bounds its field widths allow. The split of tag-only matches at the 32-segment boundary (sums of exactly 32, 33 and 35) can only be shown by the bench's directed and random scenarios. The same holds for the insensitivity to size fields below the match and for the same-cycle response.

// File: rtl/ccls_pkg.sv
package ccls_pkg;

    localparam int CLS_N = 5;

    typedef enum logic [2:0] {
        K_UNPEN     = 3'd0,
        K_PEN       = 3'd1,
        K_AVOIDED   = 3'd2,
        K_AVOIDABLE = 3'd3,
        K_UNAVOID   = 3'd4
    } ref_kind_e;

    typedef struct packed {
        logic tag_hit;
        logic data_ok;
        logic compressed;
    } lookup_t;

    function automatic logic [CLS_N-1:0] kind_to_onehot(input ref_kind_e k);
        logic [CLS_N-1:0] v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/ccls_hit_sort.sv
module ccls_hit_sort
    import ccls_pkg::*;
#(
    parameter int STACK_DEPTH = 8,
    parameter int UNCOMP_WAYS = 4,
    localparam int DW = $clog2(STACK_DEPTH)
) (
    input  logic [DW-1:0] depth,
    input  logic          compressed,
    output ref_kind_e     kind
);

    logic shallow;

    always_comb begin
        shallow = (32'(depth) < UNCOMP_WAYS);
        if (!shallow)
            kind = K_AVOIDED;
        else if (compressed)
            kind = K_PEN;
        else
            kind = K_UNPEN;
    end

endmodule

// File: rtl/ccls_stack_sum.sv
module ccls_stack_sum #(
    parameter int STACK_DEPTH = 8,
    parameter int SZW         = 4,
    parameter int SET_SEGS    = 32,
    localparam int DW   = $clog2(STACK_DEPTH),
    localparam int SMAX = (1 << SZW) - 1,
    localparam int SUMW = $clog2(STACK_DEPTH * SMAX + 1)
) (
    input  logic [STACK_DEPTH*SZW-1:0] sizes,
    input  logic [DW-1:0]              depth,
    output logic [SUMW-1:0]            total,
    output logic                       over_cap
);

    logic [SUMW-1:0] run [STACK_DEPTH];

    assign run[0] = SUMW'(sizes[SZW-1:0]);

    for (genvar i = 1; i < STACK_DEPTH; i++) begin : g_run
        assign run[i] = run[i-1] + SUMW'(sizes[i*SZW +: SZW]);
    end

    always_comb begin
        total    = run[depth];
        over_cap = (32'(total) > SET_SEGS);
    end

    // R6 / R7: the selected total lies between the size at the match and the field maximum
    always_comb begin
        if (!$isunknown({sizes, depth})) begin
            a_r6_total_bounds: assert (32'(total) >= 32'(sizes[depth*SZW +: SZW])
                && 32'(total) <= (32'(depth) + 1) * SMAX)
                else $error("stack total out of bounds");
        end
    end

endmodule

// File: rtl/ccls_ref_classifier.sv
module ccls_ref_classifier
    import ccls_pkg::*;
#(
    parameter int STACK_DEPTH = 8,
    parameter int UNCOMP_WAYS = 4,
    parameter int SZW         = 4,
    parameter int SET_SEGS    = 32,
    localparam int DW   = $clog2(STACK_DEPTH),
    localparam int SUMW = $clog2(STACK_DEPTH * ((1 << SZW) - 1) + 1)
) (
    input  logic                       lk_tag_hit,
    input  logic                       lk_data_ok,
    input  logic                       lk_compressed,
    input  logic [DW-1:0]              lk_depth,
    input  logic [STACK_DEPTH*SZW-1:0] seg_sizes,
    output logic [CLS_N-1:0]           ref_class
);

    lookup_t         lk;
    ref_kind_e       hit_kind;
    ref_kind_e       kind;
    logic [SUMW-1:0] stack_total;
    logic            over_cap;

    assign lk = '{tag_hit: lk_tag_hit, data_ok: lk_data_ok, compressed: lk_compressed};

    ccls_hit_sort #(
        .STACK_DEPTH (STACK_DEPTH),
        .UNCOMP_WAYS (UNCOMP_WAYS)
    ) u_hit (
        .depth      (lk_depth),
        .compressed (lk.compressed),
        .kind       (hit_kind)
    );

    ccls_stack_sum #(
        .STACK_DEPTH (STACK_DEPTH),
        .SZW         (SZW),
        .SET_SEGS    (SET_SEGS)
    ) u_sum (
        .sizes    (seg_sizes),
        .depth    (lk_depth),
        .total    (stack_total),
        .over_cap (over_cap)
    );

    always_comb begin
        if (!lk.tag_hit)
            kind = K_UNAVOID;
        else if (lk.data_ok)
            kind = hit_kind;
        else if (over_cap)
            kind = K_UNAVOID;
        else
            kind = K_AVOIDABLE;
        ref_class = kind_to_onehot(kind);
    end

    always_comb begin
        if (!$isunknown({lk_tag_hit, lk_data_ok, lk_compressed, lk_depth, seg_sizes})) begin
            a_r1_one_hot: assert ($onehot(ref_class))
                else $error("class not one-hot");
            a_r5_no_tag_unavoidable: assert (lk_tag_hit || ref_class[4])
                else $error("missing tag not unavoidable");
            a_r4_deep_hit_avoided: assert (!(lk_tag_hit && lk_data_ok
                && 32'(lk_depth) >= UNCOMP_WAYS) || ref_class[2])
                else $error("deep hit not avoided miss");
            a_r6_tag_only_is_miss: assert (!(lk_tag_hit && !lk_data_ok)
                || (ref_class[3] || ref_class[4]))
                else $error("tag-only match not a miss class");
        end
    end

endmodule

// File: tb/ccls_ref_classifier_test.sv
module ccls_ref_classifier_test;

    logic        clk = 1'b0;
    logic        tag_hit, data_ok, comp;
    logic [2:0]  depth;
    logic [31:0] sizes;
    logic [4:0]  cls;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    ccls_ref_classifier uut (
        .lk_tag_hit    (tag_hit),
        .lk_data_ok    (data_ok),
        .lk_compressed (comp),
        .lk_depth      (depth),
        .seg_sizes     (sizes),
        .ref_class     (cls)
    );

    function automatic logic [4:0] expect_cls(logic th, logic dv, logic cp,
                                              logic [2:0] d, logic [31:0] sz);
        int sum;
        if (!th) return 5'b10000;
        if (dv) begin
            if (d >= 4) return 5'b00100;
            return cp ? 5'b00010 : 5'b00001;
        end
        sum = 0;
        for (int i = 0; i <= int'(d); i++) sum += int'(sz[4*i +: 4]);
        return (sum > 32) ? 5'b10000 : 5'b01000;
    endfunction

    task automatic apply(logic th, logic dv, logic cp, logic [2:0] d,
                         logic [31:0] sz, string req);
        logic [4:0] e;
        @(posedge clk);
        {tag_hit, data_ok, comp, depth, sizes} = {th, dv, cp, d, sz};
        #1;
        e = expect_cls(th, dv, cp, d, sz);
        n_chk++;
        if (cls !== e) begin
            n_fail++;
            $display("FAIL %s: class=%b expected=%b", req, cls, e);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: ran out of time");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        logic [3:0]  x;
        void'($urandom(1234));
        // R5 start state: no tag
        apply(0, 0, 0, 3'd0, 32'h0, "R5 idle");
        apply(1, 1, 0, 3'd0, 32'h88888888, "R2 mru uncompressed");
        apply(1, 1, 0, 3'd3, 32'h11111111, "R2 depth4 uncompressed");
        apply(1, 1, 1, 3'd0, 32'h22222222, "R3 mru compressed");
        apply(1, 1, 1, 3'd3, 32'h22222222, "R3 depth4 compressed");
        apply(1, 1, 0, 3'd4, 32'h88888888, "R4 depth5 uncompressed");
        apply(1, 1, 1, 3'd7, 32'h88888888, "R4 depth8 compressed");
        apply(0, 1, 1, 3'd2, 32'h88888888, "R5 no tag junk inputs");
        // R6: exactly 32 over four lines
        apply(1, 0, 0, 3'd3, 32'h00008888, "R6 sum 32");
        // R7: 33
        apply(1, 0, 0, 3'd4, 32'h00018888, "R7 sum 33");
        // R7: 35 over 7 lines: 5+5+5+5+5+5+5
        apply(1, 0, 1, 3'd6, 32'h05555555, "R7 sum 35");
        // R6: 29 over 7 lines: 5,5,5,5,3,3,3
        apply(1, 0, 1, 3'd6, 32'h03335555, "R6 sum 29");
        // R8: large sizes below the match ignored
        apply(1, 0, 0, 3'd1, 32'hFFFFFF88, "R8 deep sizes ignored");
        apply(1, 0, 0, 3'd1, 32'h00000088, "R8 deep sizes zero");
        // R9: back-to-back changes seen at once
        apply(1, 0, 0, 3'd7, 32'h44444444, "R9 sum 32 at depth8");
        apply(1, 0, 0, 3'd7, 32'h54444444, "R9 sum 33 at depth8");
        for (int k = 0; k < 400; k++) begin
            s = '0;
            for (int i = 0; i < 8; i++) begin
                x = 4'(1 + ($urandom % 8));
                s[4*i +: 4] = x;
            end
            apply(1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), s,
                  "R1 R6 R7 random");
            if (cls != 0 && (cls & (cls - 1)) != 0) begin
                n_fail++;
                $display("FAIL R1: class=%b expected=one-hot", cls);
            end
            n_chk++;
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule